// File: doc/BRIEF.md
# Power-Management Event Status Register

This block holds a 16-bit set of sticky event flags for a power-management unit. Hardware sources latch their flag high when an event occurs. The flag then stays high until software writes a one to that bit position. The sources are:
- a USB resume pulse from either of two controllers;
- a ring-indicate pin, a thermal-alarm pin and an external SMI pin, all three active low;
- a lid input and an AC-present input, each flagged on any change of level;
- an SMBus summary, formed from several subsystem flags and their enables.

Asynchronous pins pass through a two-flop synchroniser, and the block keeps the previous synchronised value for edge and change detection. The SMBus and USB inputs are already synchronous to `clk_i`.

Software reads the register and writes clear masks over a simple single-register bus. The read data is the register itself, with no read latency. A per-bit enable mask selects which flags drive the level-sensitive interrupt request `irq_o`.

Top module: `pm_evt_status`

## Requirements
- R1: After reset the register reads 0000h and `irq_o` is low.
- R2: Bit 15 reads 1 on the cycle after a clock edge at which either bit of `usb_rsm_i` is high.
- R3: Bit 14 sets on a high-to-low transition of `ri_ni`. The bit is still 0 after the second rising edge following the change and reads 1 after the third. Holding `ri_ni` low does not set the bit again once it has been cleared.
- R4: Bit 13 sets on a transition of `lid_i` in either direction, three rising edges after the change.
- R5: Bit 12 sets on a transition of `acav_i` in either direction, three rising edges after the change.
- R6: Bit 10 sets on assertion (high-to-low) of `therm_ni`, and bit 9 sets on assertion of `extsmi_ni`, each three rising edges after the change.
- R7: Bit 11 sets on an edge where any of these holds: the snoop flag and its enable are both high; the host-slave flag and its enable are both high; the alert flag and its enable are both high; any bit of `smb_err_i` is high while `smb_err_en_i` is high. A flag whose enable is low has no effect.
- R8: A write (`req_i` and `we_i` high at an edge) clears every bit whose `wdata_i` bit is 1. Bits written with 0 keep their value.
- R9: If a hardware set and a software clear hit the same bit at the same edge, the bit reads 1 afterwards.
- R10: Bits 8 to 0 always read 0. Neither writes nor events change them.
- R11: `irq_o` is high exactly when some bit is 1 in both the register and `irq_en_i`. It stays high until those bits are cleared.
- R12: Deassertion of an active-low pin (a low-to-high transition) does not set its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_rsm_i | input | 2 | Resume pulses, one per USB controller (synchronous) |
| ri_ni | input | 1 | Ring-indicate pin, active low (asynchronous) |
| lid_i | input | 1 | Lid level (asynchronous) |
| acav_i | input | 1 | AC-present level (asynchronous) |
| therm_ni | input | 1 | Thermal-alarm pin, active low (asynchronous) |
| extsmi_ni | input | 1 | External SMI pin, active low (asynchronous) |
| smb_snp_i | input | 1 | SMBus snoop flag |
| smb_hslv_i | input | 1 | SMBus host-slave flag |
| smb_alrt_i | input | 1 | SMBus alert flag |
| smb_snp_en_i | input | 1 | Enable for the snoop flag |
| smb_hslv_en_i | input | 1 | Enable for the host-slave flag |
| smb_alrt_en_i | input | 1 | Enable for the alert flag |
| smb_err_i | input | 5 | Host-cycle flags: abort, collision, protocol error, cycle done, timeout |
| smb_err_en_i | input | 1 | Shared enable for `smb_err_i` |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write qualifier |
| wdata_i | input | 16 | Clear mask (1 clears) |
| rdata_o | output | 16 | Register contents |
| irq_en_i | input | 16 | Per-bit interrupt enable |
| irq_o | output | 1 | Interrupt request, level |

## Verification
On every cycle, the assertions check four things:
- no bit falls unless a one was written to it;
- a USB pulse or a qualified SMBus condition always sets its bit;
- a clear with no concurrent set always empties the bit;
- the reserved bits stay zero and `irq_o` follows the enabled register bits.

The three-edge synchroniser latency, the direction sensitivity of each pin, and the fact that a held pin level does not retrigger after a clear can only be shown by the directed scenarios. Those scenarios sample before and after the exact edge at which each bit must change.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned STS_W   = 16;
  localparam int unsigned PIN_N   = 5;
  localparam int unsigned ERR_N   = 5;
  // bit positions
  localparam int unsigned B_USB   = 15;
  localparam int unsigned B_RI    = 14;
  localparam int unsigned B_LID   = 13;
  localparam int unsigned B_ACAV  = 12;
  localparam int unsigned B_SMB   = 11;
  localparam int unsigned B_THERM = 10;
  localparam int unsigned B_EXT   = 9;
  // pin vector order
  localparam int unsigned P_EXT   = 0;
  localparam int unsigned P_THERM = 1;
  localparam int unsigned P_ACAV  = 2;
  localparam int unsigned P_LID   = 3;
  localparam int unsigned P_RI    = 4;
  localparam logic [PIN_N-1:0] PIN_CHG  = 5'b01100; // change-detect pins
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b10011; // idle level per pin
  localparam logic [STS_W-1:0] IMPL_MASK =
    (STS_W'(1) << B_USB) | (STS_W'(1) << B_RI) | (STS_W'(1) << B_LID) |
    (STS_W'(1) << B_ACAV) | (STS_W'(1) << B_SMB) | (STS_W'(1) << B_THERM) |
    (STS_W'(1) << B_EXT);
endpackage

// File: rtl/pm_evt_sync.sv
module pm_evt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) ff_q[s] <= RST_VAL;
    end else begin
      ff_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pm_evt_pin_det.sv
module pm_evt_pin_det #(
  parameter int unsigned N = 5,
  parameter logic [N-1:0] CHG_MASK = '0,
  parameter logic [N-1:0] IDLE_LVL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] sync_q, prev_q;

  pm_evt_sync #(.W(N), .STAGES(2), .RST_VAL(IDLE_LVL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_LVL;
    else         prev_q <= sync_q;
  end

  for (genvar i = 0; i < int'(N); i++) begin : g_det
    if (CHG_MASK[i]) begin : g_chg
      assign hit_o[i] = sync_q[i] ^ prev_q[i];
    end else begin : g_fall
      // active-low assertion
      assign hit_o[i] = prev_q[i] & ~sync_q[i];
    end
  end
endmodule

// File: rtl/pm_evt_smb_agg.sv
module pm_evt_smb_agg #(
  parameter int unsigned ERR_N = 5
) (
  input  logic             snp_i,
  input  logic             hslv_i,
  input  logic             alrt_i,
  input  logic             snp_en_i,
  input  logic             hslv_en_i,
  input  logic             alrt_en_i,
  input  logic [ERR_N-1:0] err_i,
  input  logic             err_en_i,
  output logic             hit_o
);
  logic flag_hit, err_hit;

  assign flag_hit = (snp_i & snp_en_i) | (hslv_i & hslv_en_i) | (alrt_i & alrt_en_i);
  assign err_hit  = (|err_i) & err_en_i;
  assign hit_o    = flag_hit | err_hit;
endmodule

// File: rtl/pm_evt_sts_reg.sv
module pm_evt_sts_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q, sts_d;

  // set dominates clear
  assign sts_d = ((sts_q & ~clr_i) | set_i) & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_evt_pkg::*;
#(
  parameter int unsigned W = STS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       usb_rsm_i,
  input  logic             ri_ni,
  input  logic             lid_i,
  input  logic             acav_i,
  input  logic             therm_ni,
  input  logic             extsmi_ni,
  input  logic             smb_snp_i,
  input  logic             smb_hslv_i,
  input  logic             smb_alrt_i,
  input  logic             smb_snp_en_i,
  input  logic             smb_hslv_en_i,
  input  logic             smb_alrt_en_i,
  input  logic [ERR_N-1:0] smb_err_i,
  input  logic             smb_err_en_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  input  logic [W-1:0]     irq_en_i,
  output logic             irq_o
);
  logic [PIN_N-1:0] pin_vec, pin_hit;
  logic             smb_hit;
  logic [W-1:0]     set_vec, clr_vec, sts;

  always_comb begin
    pin_vec          = '0;
    pin_vec[P_EXT]   = extsmi_ni;
    pin_vec[P_THERM] = therm_ni;
    pin_vec[P_ACAV]  = acav_i;
    pin_vec[P_LID]   = lid_i;
    pin_vec[P_RI]    = ri_ni;
  end

  pm_evt_pin_det #(.N(PIN_N), .CHG_MASK(PIN_CHG), .IDLE_LVL(PIN_IDLE)) u_pins (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_vec),
    .hit_o (pin_hit)
  );

  pm_evt_smb_agg #(.ERR_N(ERR_N)) u_smb (
    .snp_i    (smb_snp_i),
    .hslv_i   (smb_hslv_i),
    .alrt_i   (smb_alrt_i),
    .snp_en_i (smb_snp_en_i),
    .hslv_en_i(smb_hslv_en_i),
    .alrt_en_i(smb_alrt_en_i),
    .err_i    (smb_err_i),
    .err_en_i (smb_err_en_i),
    .hit_o    (smb_hit)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_USB]   = |usb_rsm_i;
    set_vec[B_RI]    = pin_hit[P_RI];
    set_vec[B_LID]   = pin_hit[P_LID];
    set_vec[B_ACAV]  = pin_hit[P_ACAV];
    set_vec[B_SMB]   = smb_hit;
    set_vec[B_THERM] = pin_hit[P_THERM];
    set_vec[B_EXT]   = pin_hit[P_EXT];
  end

  assign clr_vec = (req_i && we_i) ? wdata_i : '0;

  pm_evt_sts_reg #(.W(W), .IMPL(IMPL_MASK)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .sts_o (sts)
  );

  assign rdata_o = sts;
  assign irq_o   = |(sts & irq_en_i);
endmodule

// File: rtl/pm_evt_chk.sv
module pm_evt_chk #(
  parameter int unsigned W = 16,
  parameter int unsigned ERR_N = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       usb_rsm_i,
  input  logic             smb_snp_i,
  input  logic             smb_hslv_i,
  input  logic             smb_alrt_i,
  input  logic             smb_snp_en_i,
  input  logic             smb_hslv_en_i,
  input  logic             smb_alrt_en_i,
  input  logic [ERR_N-1:0] smb_err_i,
  input  logic             smb_err_en_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     rdata_o,
  input  logic [W-1:0]     irq_en_i,
  input  logic             irq_o
);
  logic [W-1:0] wmask;
  logic         smb_cond;

  assign wmask    = (req_i && we_i) ? wdata_i : '0;
  assign smb_cond = (smb_snp_i & smb_snp_en_i) | (smb_hslv_i & smb_hslv_en_i) |
                    (smb_alrt_i & smb_alrt_en_i) | ((|smb_err_i) & smb_err_en_i);

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(rdata_o) & ~$past(wmask)) & ~rdata_o) == '0));

  // R2
  usb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|usb_rsm_i) |=> rdata_o[15]);

  // R7
  smb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_cond |=> rdata_o[11]);

  // R9
  usb_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|usb_rsm_i) && wmask[15]) |=> rdata_o[15]);

  // R8
  usb_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wmask[15] && !(|usb_rsm_i)) |=> !rdata_o[15]);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[8:0] == '0);

  // R11
  irq_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(rdata_o & irq_en_i)));
endmodule

bind pm_evt_status pm_evt_chk #(.W(W), .ERR_N(pm_evt_pkg::ERR_N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .usb_rsm_i    (usb_rsm_i),
  .smb_snp_i    (smb_snp_i),
  .smb_hslv_i   (smb_hslv_i),
  .smb_alrt_i   (smb_alrt_i),
  .smb_snp_en_i (smb_snp_en_i),
  .smb_hslv_en_i(smb_hslv_en_i),
  .smb_alrt_en_i(smb_alrt_en_i),
  .smb_err_i    (smb_err_i),
  .smb_err_en_i (smb_err_en_i),
  .req_i        (req_i),
  .we_i         (we_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .irq_en_i     (irq_en_i),
  .irq_o        (irq_o)
);

// File: tb/sim_pm_evt_status.sv
`timescale 1ns/1ps
module sim_pm_evt_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  usb_rsm_i = '0;
  logic        ri_ni = 1'b1, lid_i = 1'b0, acav_i = 1'b0;
  logic        therm_ni = 1'b1, extsmi_ni = 1'b1;
  logic        smb_snp_i = 0, smb_hslv_i = 0, smb_alrt_i = 0;
  logic        smb_snp_en_i = 0, smb_hslv_en_i = 0, smb_alrt_en_i = 0;
  logic [4:0]  smb_err_i = '0;
  logic        smb_err_en_i = 0;
  logic        req_i = 0, we_i = 0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [15:0] irq_en_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pm_evt_status u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .usb_rsm_i(usb_rsm_i),
    .ri_ni(ri_ni), .lid_i(lid_i), .acav_i(acav_i),
    .therm_ni(therm_ni), .extsmi_ni(extsmi_ni),
    .smb_snp_i(smb_snp_i), .smb_hslv_i(smb_hslv_i), .smb_alrt_i(smb_alrt_i),
    .smb_snp_en_i(smb_snp_en_i), .smb_hslv_en_i(smb_hslv_en_i),
    .smb_alrt_en_i(smb_alrt_en_i), .smb_err_i(smb_err_i),
    .smb_err_en_i(smb_err_en_i), .req_i(req_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clr(input logic [15:0] m);
    req_i = 1; we_i = 1; wdata_i = m;
    tick(1);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    tick(3);
    chk("R1 rdata", rdata_o, 16'h0000);
    chk("R1 irq", {15'b0, irq_o}, 16'h0000);
    rst_ni = 1;
    tick(4);
    chk("R1 idle", rdata_o, 16'h0000);
  endtask

  task automatic t_usb();
    usb_rsm_i = 2'b10;
    tick(1);
    usb_rsm_i = 2'b00;
    chk("R2 ctrl1", rdata_o, 16'h8000);
    clr(16'h8000);
    chk("R8 clr15", rdata_o, 16'h0000);
    usb_rsm_i = 2'b01;
    tick(1);
    usb_rsm_i = 2'b00;
    chk("R2 ctrl0", rdata_o, 16'h8000);
    clr(16'h8000);
  endtask

  task automatic t_ri();
    ri_ni = 0;
    tick(2);
    chk("R3 latency2", rdata_o, 16'h0000);
    tick(1);
    chk("R3 set", rdata_o, 16'h4000);
    clr(16'h4000);
    tick(4);
    chk("R3 held low", rdata_o, 16'h0000);
    ri_ni = 1;
    tick(4);
    chk("R12 ri release", rdata_o, 16'h0000);
  endtask

  task automatic t_lid_acav();
    lid_i = 1;
    tick(3);
    chk("R4 lid rise", rdata_o, 16'h2000);
    clr(16'h2000);
    lid_i = 0;
    tick(3);
    chk("R4 lid fall", rdata_o, 16'h2000);
    clr(16'h2000);
    acav_i = 1;
    tick(3);
    chk("R5 acav rise", rdata_o, 16'h1000);
    clr(16'h1000);
    acav_i = 0;
    tick(3);
    chk("R5 acav fall", rdata_o, 16'h1000);
    clr(16'h1000);
  endtask

  task automatic t_therm_ext();
    therm_ni = 0;
    tick(3);
    chk("R6 therm", rdata_o, 16'h0400);
    extsmi_ni = 0;
    tick(3);
    chk("R6 extsmi", rdata_o, 16'h0600);
    clr(16'h0600);
    therm_ni = 1; extsmi_ni = 1;
    tick(4);
    chk("R12 release", rdata_o, 16'h0000);
  endtask

  task automatic t_smb();
    smb_snp_i = 1; smb_hslv_i = 1; smb_alrt_i = 1; smb_err_i = 5'h1F;
    tick(2);
    chk("R7 no enable", rdata_o, 16'h0000);
    smb_snp_i = 0; smb_hslv_i = 0; smb_err_i = '0;
    smb_alrt_en_i = 1;
    tick(1);
    chk("R7 alert", rdata_o, 16'h0800);
    smb_alrt_i = 0; smb_alrt_en_i = 0;
    clr(16'h0800);
    smb_err_i = 5'b01000; smb_err_en_i = 1;
    tick(1);
    chk("R7 err", rdata_o, 16'h0800);
    // R9 set wins while condition holds
    clr(16'h0800);
    chk("R9 set wins", rdata_o, 16'h0800);
    smb_err_i = '0; smb_err_en_i = 0;
    clr(16'h0800);
    chk("R8 smb clr", rdata_o, 16'h0000);
    smb_hslv_i = 1; smb_hslv_en_i = 1;
    tick(1);
    smb_hslv_i = 0; smb_hslv_en_i = 0;
    chk("R7 hslv", rdata_o, 16'h0800);
    clr(16'h0800);
  endtask

  task automatic t_mix();
    usb_rsm_i = 2'b01; smb_snp_i = 1; smb_snp_en_i = 1;
    tick(1);
    usb_rsm_i = 0; smb_snp_i = 0; smb_snp_en_i = 0;
    chk("R2 R7 both", rdata_o, 16'h8800);
    clr(16'h01FF);
    chk("R10 rsvd write", rdata_o, 16'h8800);
    clr(16'h0000);
    chk("R8 zero write", rdata_o, 16'h8800);
    irq_en_i = 16'h0401;
    tick(1);
    chk("R11 masked", {15'b0, irq_o}, 16'h0000);
    irq_en_i = 16'h0800;
    tick(1);
    chk("R11 enabled", {15'b0, irq_o}, 16'h0001);
    clr(16'h0800);
    chk("R8 isolate", rdata_o, 16'h8000);
    chk("R11 drop", {15'b0, irq_o}, 16'h0000);
    irq_en_i = 16'h8000;
    tick(1);
    chk("R11 level", {15'b0, irq_o}, 16'h0001);
    // R9 usb pulse concurrent with clear
    usb_rsm_i = 2'b11; req_i = 1; we_i = 1; wdata_i = 16'hFFFF;
    tick(1);
    usb_rsm_i = 0; req_i = 0; we_i = 0; wdata_i = 0;
    chk("R9 usb wins", rdata_o, 16'h8000);
    clr(16'hFFFF);
    chk("R8 all clr", rdata_o, 16'h0000);
    chk("R11 off", {15'b0, irq_o}, 16'h0000);
  endtask

  initial begin
    fork
      begin
        tick(4000);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", n_err, n_chk);
          $finish;
        end
      end
    join_none
    tick(1);
    t_reset();
    t_usb();
    t_ri();
    t_lid_acav();
    t_therm_ext();
    t_smb();
    t_mix();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule